// File: doc/BRIEF.md
# Block loudness meter with PWM output

This block turns a stream of signed audio samples into a brightness level for an LED. It adds up the squares of the samples in fixed-size blocks. When a block is full it turns the total into a duty value, and a free-running counter compares against that value to drive a PWM pin. The intended use is a visual loudness indicator. The cost is kept to one multiplier, one adder and a few shifts.

The block length is a power of two, so dividing by it is a shift. Instead of a square root, the mean is shifted right by one bit. The result is then shifted right by a further eight bits and its low bits form the duty. The duty register is refreshed once per block. The PWM comparator only picks up the new duty when its counter wraps, so no period is ever cut short.

Top module: `rms_pwm_level`

## Requirements
- R1: Each sample accepted with `sampleValid` high is interpreted as two's-complement and its square is added to the block total, so a negative sample adds the same amount as its magnitude.
- R2: Cycles with `sampleValid` low leave the block total and the sample count unchanged, whatever value `sampleIn` carries.
- R3: At the end of a block, `dutyOut` is set to bits [DUTY_W-1:0] of (total >> (BLK_LOG2 + 1 + 8)). This is the mean, then one root-approximation shift, then the eight-bit output shift, truncated.
- R4: `dutyOut` changes only on the clock edge that accepts the last sample of a block, and is valid from the cycle after that edge. Between those edges it holds its value.
- R5: Each block holds exactly 2^BLK_LOG2 accepted samples. The sample that completes a block counts toward that block's total, and the total restarts from zero for the next block.
- R6: The block total is an unsigned ACC_W-bit accumulator (64 by default) that wraps modulo 2^ACC_W.
- R7: A DUTY_W-bit PWM counter advances every cycle and wraps from all ones to zero. `pwmOut` is high exactly while the counter is below the active duty value.
- R8: The active duty copies `dutyOut` only on the edge where the counter wraps from all ones to zero, so a new duty first takes effect at the start of the next PWM period.
- R9: While `rst` (synchronous, active high) is asserted, `dutyOut`, the active duty, the PWM counter, the block total and the sample count are cleared, so `pwmOut` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleIn | input | SAMPLE_W | Signed audio sample |
| sampleValid | input | 1 | Qualifies `sampleIn` for one cycle |
| dutyOut | output | DUTY_W | Duty value computed from the last completed block |
| pwmOut | output | 1 | PWM drive |

## Verification
The bench builds the block with BLK_LOG2 = 2 and DUTY_W = 8; all other parameters keep their defaults. Four-sample blocks let many block boundaries, idle gaps between samples and reads in the middle of a block fit into a short run. A 256-cycle PWM period lets the bench watch several counter wraps and the delayed pickup of each new duty, and measure a whole period's high time. Full-scale negative samples push the default 64-bit total to its wrap point.

// File: rtl/rms_pwm_pkg.sv
package rms_pwm_pkg;
  // Strobes from the sample sequencer to the energy datapath
  typedef struct packed {
    logic accAdd;   // a valid sample is present this cycle
    logic blkEnd;   // this sample completes the current block
  } rmsCtrl_t;
endpackage

// File: rtl/rms_pwm_ctrl.sv
module rms_pwm_ctrl
  import rms_pwm_pkg::*;
#(
  parameter int BLK_LOG2 = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     sampleValid,
  output rmsCtrl_t ctrl
);
  localparam int CNT_W = (BLK_LOG2 > 0) ? BLK_LOG2 : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'((1 << BLK_LOG2) - 1);

  logic [CNT_W-1:0] sampleCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sampleCnt <= '0;
    end else if (sampleValid) begin
      sampleCnt <= (sampleCnt == LAST_IDX) ? '0 : sampleCnt + 1'b1;
    end
  end

  always_comb begin
    ctrl.accAdd = sampleValid;
    ctrl.blkEnd = sampleValid && (sampleCnt == LAST_IDX);
  end
endmodule

// File: rtl/rms_pwm_datapath.sv
module rms_pwm_datapath
  import rms_pwm_pkg::*;
#(
  parameter int SAMPLE_W   = 32,
  parameter int ACC_W      = 64,
  parameter int BLK_LOG2   = 8,
  parameter int ROOT_SHIFT = 1,
  parameter int OUT_SHIFT  = 8,
  parameter int DUTY_W     = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  rmsCtrl_t                   ctrl,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  output logic        [DUTY_W-1:0]   dutyOut
);
  localparam int PROD_W      = 2 * SAMPLE_W;
  localparam int SHIFT_TOTAL = BLK_LOG2 + ROOT_SHIFT + OUT_SHIFT;

  logic signed [PROD_W-1:0] sqFull;
  logic        [ACC_W-1:0]  sqExt;
  logic        [ACC_W-1:0]  accSum;
  logic        [ACC_W-1:0]  nextSum;
  logic        [ACC_W-1:0]  scaled;
  logic        [DUTY_W-1:0] dutyNext;

  assign sqFull = sampleIn * sampleIn;

  // The accumulator width picks how the square is fitted into it
  generate
    if (ACC_W >= PROD_W) begin : g_wideAcc
      assign sqExt = ACC_W'($unsigned(sqFull));
    end else begin : g_narrowAcc
      assign sqExt = sqFull[ACC_W-1:0];
    end
  endgenerate

  assign nextSum  = accSum + sqExt;
  assign scaled   = nextSum >> SHIFT_TOTAL;
  assign dutyNext = scaled[DUTY_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      accSum  <= '0;
      dutyOut <= '0;
    end else if (ctrl.accAdd) begin
      if (ctrl.blkEnd) begin
        accSum  <= '0;
        dutyOut <= dutyNext;
      end else begin
        accSum  <= nextSum;
      end
    end
  end
endmodule

// File: rtl/rms_pwm_gen.sv
module rms_pwm_gen #(
  parameter int DUTY_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DUTY_W-1:0] dutyIn,
  output logic [DUTY_W-1:0] pwmCnt,
  output logic [DUTY_W-1:0] activeDuty,
  output logic              pwmOut
);
  localparam logic [DUTY_W-1:0] CNT_TOP = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwmCnt     <= '0;
      activeDuty <= '0;
    end else begin
      pwmCnt <= pwmCnt + 1'b1;
      if (pwmCnt == CNT_TOP) begin
        activeDuty <= dutyIn;
      end
    end
  end

  assign pwmOut = (pwmCnt < activeDuty);
endmodule

// File: rtl/rms_pwm_level.sv
module rms_pwm_level
  import rms_pwm_pkg::*;
#(
  parameter int SAMPLE_W   = 32,
  parameter int ACC_W      = 64,
  parameter int BLK_LOG2   = 8,
  parameter int ROOT_SHIFT = 1,
  parameter int OUT_SHIFT  = 8,
  parameter int DUTY_W     = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic                       sampleValid,
  output logic        [DUTY_W-1:0]   dutyOut,
  output logic                       pwmOut
);
  rmsCtrl_t          ctrlBus;
  logic [DUTY_W-1:0] pwmCnt;
  logic [DUTY_W-1:0] activeDuty;

  rms_pwm_ctrl #(.BLK_LOG2(BLK_LOG2)) u_ctrl (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .ctrl(ctrlBus)
  );

  rms_pwm_datapath #(
    .SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .BLK_LOG2(BLK_LOG2),
    .ROOT_SHIFT(ROOT_SHIFT), .OUT_SHIFT(OUT_SHIFT), .DUTY_W(DUTY_W)
  ) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrlBus), .sampleIn(sampleIn), .dutyOut(dutyOut)
  );

  rms_pwm_gen #(.DUTY_W(DUTY_W)) u_pwm (
    .clk(clk), .rst(rst), .dutyIn(dutyOut),
    .pwmCnt(pwmCnt), .activeDuty(activeDuty), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/rms_pwm_level_chk.sv
module rms_pwm_level_chk
  import rms_pwm_pkg::*;
#(
  parameter int DUTY_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              sampleValid,
  input rmsCtrl_t          ctrlBus,
  input logic [DUTY_W-1:0] dutyOut,
  input logic [DUTY_W-1:0] pwmCnt,
  input logic [DUTY_W-1:0] activeDuty,
  input logic              pwmOut
);
  localparam logic [DUTY_W-1:0] CNT_TOP = '1;

  p_reset_state_r9: assert property (@(posedge clk)
    rst |=> (dutyOut == '0 && !pwmOut));

  p_block_needs_valid_r2: assert property (@(posedge clk) disable iff (rst)
    ctrlBus.blkEnd |-> sampleValid);

  p_duty_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !ctrlBus.blkEnd |=> $stable(dutyOut));

  p_count_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (pwmCnt == CNT_TOP) |=> (pwmCnt == '0));

  p_rise_at_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(pwmOut) |-> (pwmCnt == '0));

  p_load_at_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (pwmCnt != CNT_TOP) |=> $stable(activeDuty));
endmodule

bind rms_pwm_level rms_pwm_level_chk #(.DUTY_W(DUTY_W)) u_chk (
  .clk(clk), .rst(rst), .sampleValid(sampleValid), .ctrlBus(ctrlBus),
  .dutyOut(dutyOut), .pwmCnt(pwmCnt), .activeDuty(activeDuty), .pwmOut(pwmOut)
);

// File: tb/sim_rms_pwm_level.sv
`timescale 1ns/1ps
module sim_rms_pwm_level;
  localparam int SW    = 32;
  localparam int AW    = 64;
  localparam int BL    = 2;
  localparam int DW    = 8;
  localparam int BLK   = 1 << BL;
  localparam int SHIFT = BL + 1 + 8;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic signed [SW-1:0] sampleIn = '0;
  logic                 sampleValid = 1'b0;
  logic        [DW-1:0] dutyOut;
  logic                 pwmOut;

  always #4 clk = ~clk;

  rms_pwm_level #(.SAMPLE_W(SW), .ACC_W(AW), .BLK_LOG2(BL), .DUTY_W(DW)) u0 (
    .clk(clk), .rst(rst), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .dutyOut(dutyOut), .pwmOut(pwmOut)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [DW-1:0] expQ[$];
  logic [AW-1:0] benchSum = '0;
  int benchCnt = 0;
  logic [DW-1:0] lastDuty = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: idle cycles with junk data, then one valid sample; predicts the duty
  task automatic sendSample(input logic signed [SW-1:0] v, input int idle);
    logic [AW-1:0] sq;
    for (int i = 0; i < idle; i++) begin
      @(negedge clk);
      sampleValid = 1'b0;
      sampleIn = $signed(32'h7fff_fff0 ^ 32'(i));
    end
    @(negedge clk);
    sampleIn = v;
    sampleValid = 1'b1;
    @(posedge clk);
    sq = 64'(longint'(v) * longint'(v));
    benchSum = benchSum + sq;
    benchCnt++;
    if (benchCnt == BLK) begin
      lastDuty = DW'(benchSum >> SHIFT);
      expQ.push_back(lastDuty);
      benchSum = '0;
      benchCnt = 0;
    end
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  // Monitor: compare each predicted duty on the cycle after its block closes
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [DW-1:0] e;
      e = expQ.pop_front();
      check(dutyOut == e, "R1 R3 R5", "block duty", dutyOut, e);
    end
  end

  // PWM reference for R7 and R8, tracked from the spec
  logic [DW-1:0] mCnt = '0;
  logic [DW-1:0] mAct = '0;
  logic [DW-1:0] prevDuty = '0;
  int pwmErr = 0;
  always @(negedge clk) begin
    if (rst) begin
      mCnt = '0;
      mAct = '0;
    end else begin
      if (mCnt == DW'((1 << DW) - 1)) mAct = prevDuty;
      mCnt = mCnt + 1'b1;
    end
    if (pwmOut !== (mCnt < mAct)) pwmErr++;
    prevDuty = dutyOut;
  end

  initial begin
    int highCnt;
    repeat (3) @(negedge clk);
    check(dutyOut == '0, "R9", "duty in reset", dutyOut, 0);
    check(pwmOut == 1'b0, "R9", "pwm in reset", pwmOut, 0);
    #1 rst = 1'b0;

    // plain block
    for (int i = 0; i < BLK; i++) sendSample(2000, 0);
    // mixed signs, same energy (R1)
    for (int i = 0; i < BLK; i++) sendSample((i % 2) ? 2000 : -2000, 0);
    // R4: duty holds in mid-block
    for (int i = 0; i < BLK - 1; i++) sendSample((i % 2) ? -100 : 100, 0);
    check(dutyOut == lastDuty, "R4", "mid-block hold", dutyOut, lastDuty);
    sendSample(-100, 0);
    // R2: junk samples with valid low between accepted ones
    sendSample(300, 3);
    sendSample(-700, 2);
    sendSample(1100, 5);
    sendSample(0, 1);
    repeat (20) @(negedge clk);
    check(dutyOut == lastDuty, "R4", "idle hold", dutyOut, lastDuty);
    // R6: full-scale negative samples reach the accumulator wrap
    for (int i = 0; i < BLK; i++) sendSample(32'sh8000_0000, 0);
    for (int i = 0; i < BLK; i++) sendSample(46341 + i * 777, 0);
    for (int i = 0; i < BLK; i++) sendSample(-123456 * (i + 1), 1);
    // final level for the PWM measurement
    for (int i = 0; i < BLK; i++) sendSample(2000, 0);
    repeat (600) @(negedge clk);
    highCnt = 0;
    for (int i = 0; i < (1 << DW); i++) begin
      @(negedge clk);
      if (pwmOut) highCnt++;
    end
    check(highCnt == int'(lastDuty), "R7", "high cycles per period", highCnt, lastDuty);
    check(pwmErr == 0, "R8", "pwm pickup at wrap mismatches", pwmErr, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule